// File: doc/BRIEF.md
# Register-Operate Execution Unit with Condition Flags

This block performs the arithmetic and logic step for a small 16-bit load/store processor that has eight general registers. It receives one instruction word and the two values already read from the register file. It supports three operations: two's-complement addition, bitwise AND, and bitwise complement. For each one it returns the destination register index, a write strobe and the 16-bit result. All three outputs are registered and appear one clock after the instruction is presented. The two source register indices are driven combinationally from the instruction word, so the register file can be read in the same cycle.

The block also holds the processor's three condition flags: negative, zero and positive. Exactly one flag is set at any time. The flags are stored as a three-state machine with the states `CC_NEG`, `CC_ZERO` and `CC_POS`, and `CC_ZERO` is the reset state. From any state the machine moves to the state that classifies the most recent value written to a general register. That value may come from this unit's own result, or from the separate write-back port used by loads and address computations. When no write occurs in a cycle, the machine takes its self-transition and the flags hold.

Top module: `opx_unit`

## Requirements
- R1: With instr_valid high, opcode instr[15:12] = 0001 and instr[5] = 0, the next cycle shows rf_we = 1, rf_dst = instr[11:9] and rf_data = src_a + src_b modulo 2^16.
- R2: When instr[5] = 1 on an add or AND, the second operand is instr[4:0] sign-extended to 16 bits (00101 gives +5, 11110 gives -2), and src_b is ignored.
- R3: Opcode 0101 produces the bitwise AND of src_a and the second operand, with the same register or immediate selection as R1 and R2.
- R4: Opcode 1001 produces the bitwise complement of src_a, whatever the values of instr[5] and src_b.
- R5: rd_a_idx always equals instr[8:6] and rd_b_idx always equals instr[2:0], in the same cycle, so that a source may name the destination register and still read its old value.
- R6: Exactly one of flag_n, flag_z and flag_p is high at all times. After reset, flag_z is the one set.
- R7: After an operate result is written, the flags classify rf_data: flag_n when bit 15 is set, flag_z when the value is zero, and flag_p otherwise.
- R8: A cycle with wb_valid high and no operate write updates the flags one cycle later by the same rule applied to wb_data, and does not raise rf_we.
- R9: When an operate write and wb_valid occur in the same cycle, the flags classify the operate result.
- R10: When instr_valid is low, or the opcode is not one of 0001, 0101 and 1001, rf_we stays low. The flags then hold unless wb_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | Register-file value read at rd_a_idx |
| src_b | input | 16 | Register-file value read at rd_b_idx |
| wb_valid | input | 1 | A load or address result is being written to a register |
| wb_data | input | 16 | Value of that write-back |
| rd_a_idx | output | 3 | First source register index |
| rd_b_idx | output | 3 | Second source register index |
| rf_we | output | 1 | Operate result write strobe |
| rf_dst | output | 3 | Destination register index |
| rf_data | output | 16 | Operate result |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
The hardest situation to create is a cycle in which an operate write and a write-back arrive together and the two values would produce different flags. Only that case shows which source wins. Random stimulus raises wb_valid on about one cycle in three, alongside random operations, so these collisions occur often. Directed cases add a collision with a positive result against a negative write-back. The transitions into `CC_NEG` and `CC_ZERO` also need specific values: an add that overflows past 0x7FFF, an AND of complementary patterns, and a complement of 0xFFFF. Corner operand values are injected into the random stream so that each of these transitions is taken many times.

// File: rtl/opx_pkg.sv
package opx_pkg;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_NOT  = 2'd3
    } alu_op_t;

    typedef enum logic [1:0] {
        CC_NEG  = 2'd0,
        CC_ZERO = 2'd1,
        CC_POS  = 2'd2
    } cc_state_t;

endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int INSTR_W = 16,
    parameter int IDX_W   = 3,
    parameter int IMM_W   = 5
) (
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    output logic [IDX_W-1:0]   rd_a_idx,
    output logic [IDX_W-1:0]   rd_b_idx,
    output logic [IDX_W-1:0]   dst_idx,
    output alu_op_t            op_sel,
    output logic               op_write,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b
);
    localparam int OPC_LSB  = INSTR_W - 4;
    localparam int DST_LSB  = OPC_LSB - IDX_W;
    localparam int SRC1_LSB = DST_LSB - IDX_W;
    localparam int MODE_BIT = SRC1_LSB - 1;
    localparam int EXT_W    = DATA_W - IMM_W;

    logic [3:0]        opc;
    logic [DATA_W-1:0] imm_ext;

    assign opc      = instr[INSTR_W-1:OPC_LSB];
    assign dst_idx  = instr[DST_LSB+IDX_W-1:DST_LSB];
    assign rd_a_idx = instr[SRC1_LSB+IDX_W-1:SRC1_LSB];
    assign rd_b_idx = instr[IDX_W-1:0];
    assign imm_ext  = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    always_comb begin
        unique case (opc)
            OPC_ADD: op_sel = ALU_ADD;
            OPC_AND: op_sel = ALU_AND;
            OPC_NOT: op_sel = ALU_NOT;
            default: op_sel = ALU_NONE;
        endcase
    end

    assign op_write = instr_valid && (op_sel != ALU_NONE);
    assign opnd_a   = src_a;
    assign opnd_b   = instr[MODE_BIT] ? imm_ext : src_b;

endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (op_sel)
            ALU_ADD:  result = opnd_a + opnd_b;
            ALU_AND:  result = opnd_a & opnd_b;
            ALU_NOT:  result = ~opnd_a;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/opx_ccreg.sv
module opx_ccreg
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_we,
    input  logic [DATA_W-1:0] op_val,
    input  logic              wb_we,
    input  logic [DATA_W-1:0] wb_val,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p
);
    cc_state_t         state_q;
    cc_state_t         state_d;
    logic [DATA_W-1:0] sample;

    // the operate result outranks a write-back landing in the same cycle
    assign sample = op_we ? op_val : wb_val;

    always_comb begin
        state_d = state_q;
        if (op_we || wb_we) begin
            if (sample[DATA_W-1])
                state_d = CC_NEG;
            else if (sample == '0)
                state_d = CC_ZERO;
            else
                state_d = CC_POS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CC_ZERO;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CC_NEG:  {flag_n, flag_z, flag_p} = 3'b100;
            CC_ZERO: {flag_n, flag_z, flag_p} = 3'b010;
            CC_POS:  {flag_n, flag_z, flag_p} = 3'b001;
            default: {flag_n, flag_z, flag_p} = 3'b010;
        endcase
    end
endmodule

// File: rtl/opx_unit.sv
module opx_unit
    import opx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int INSTR_W = 16,
    parameter int IDX_W   = 3,
    parameter int IMM_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic               wb_valid,
    input  logic [DATA_W-1:0]  wb_data,
    output logic [IDX_W-1:0]   rd_a_idx,
    output logic [IDX_W-1:0]   rd_b_idx,
    output logic               rf_we,
    output logic [IDX_W-1:0]   rf_dst,
    output logic [DATA_W-1:0]  rf_data,
    output logic               flag_n,
    output logic               flag_z,
    output logic               flag_p
);
    alu_op_t           op_sel;
    logic              op_write;
    logic [IDX_W-1:0]  dst_idx;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] result;

    opx_decode #(
        .DATA_W(DATA_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W), .IMM_W(IMM_W)
    ) u_dec (
        .instr_valid(instr_valid),
        .instr      (instr),
        .src_a      (src_a),
        .src_b      (src_b),
        .rd_a_idx   (rd_a_idx),
        .rd_b_idx   (rd_b_idx),
        .dst_idx    (dst_idx),
        .op_sel     (op_sel),
        .op_write   (op_write),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    opx_alu #(.DATA_W(DATA_W)) u_alu (
        .op_sel(op_sel),
        .opnd_a(opnd_a),
        .opnd_b(opnd_b),
        .result(result)
    );

    opx_ccreg #(.DATA_W(DATA_W)) u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .op_we (op_write),
        .op_val(result),
        .wb_we (wb_valid),
        .wb_val(wb_data),
        .flag_n(flag_n),
        .flag_z(flag_z),
        .flag_p(flag_p)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_we   <= 1'b0;
            rf_dst  <= '0;
            rf_data <= '0;
        end else begin
            rf_we <= op_write;
            if (op_write) begin
                rf_dst  <= dst_idx;
                rf_data <= result;
            end
        end
    end
endmodule

// File: rtl/opx_unit_chk.sv
module opx_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data,
    input logic              rf_we,
    input logic [DATA_W-1:0] rf_data,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_p
);
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({flag_n, flag_z, flag_p})); // R6

    AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (flag_n == rf_data[DATA_W-1]) && (flag_z == (rf_data == '0))); // R7

    AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wb_valid) && !rf_we) |->
            (flag_n == $past(wb_data[DATA_W-1])) && (flag_z == ($past(wb_data) == '0))); // R8

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(instr_valid) |-> !rf_we); // R10

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rf_we && !$past(wb_valid)) |-> $stable({flag_n, flag_z, flag_p})); // R10
endmodule

bind opx_unit opx_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .wb_valid   (wb_valid),
    .wb_data    (wb_data),
    .rf_we      (rf_we),
    .rf_data    (rf_data),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_p     (flag_p)
);

// File: tb/opx_unit_test.sv
`timescale 1ns/1ps
module opx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic        wb_valid = 1'b0;
    logic [15:0] wb_data = '0;
    logic [2:0]  rd_a_idx, rd_b_idx, rf_dst;
    logic        rf_we, flag_n, flag_z, flag_p;
    logic [15:0] rf_data;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_cc = 3'b010;

    always #4 clk = ~clk;

    opx_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .wb_valid(wb_valid), .wb_data(wb_data),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rf_we(rf_we), .rf_dst(rf_dst),
        .rf_data(rf_data), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    function automatic logic [2:0] classify(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [15:0] mk(input logic [3:0] opc, input logic [2:0] d,
                                       input logic [2:0] s1, input logic md,
                                       input logic [4:0] lo);
        return {opc, d, s1, md, lo};
    endfunction

    function automatic logic [15:0] model(input logic [15:0] ir, input logic [15:0] a,
                                          input logic [15:0] b);
        logic [15:0] opb;
        opb = ir[5] ? {{11{ir[4]}}, ir[4:0]} : b;
        case (ir[15:12])
            4'b0001: return a + opb;
            4'b0101: return a & opb;
            4'b1001: return ~a;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] ir, input logic [15:0] a,
                        input logic [15:0] b, input logic wv, input logic [15:0] wd);
        logic        is_op;
        logic [15:0] res;
        string       rtag, ftag;
        instr_valid = v; instr = ir; src_a = a; src_b = b;
        wb_valid = wv; wb_data = wd;
        #1;
        chk(rd_a_idx == ir[8:6] && rd_b_idx == ir[2:0], "R5 source index",
            {10'h0, rd_a_idx, rd_b_idx}, {10'h0, ir[8:6], ir[2:0]});
        is_op = v && (ir[15:12] == 4'b0001 || ir[15:12] == 4'b0101 || ir[15:12] == 4'b1001);
        res = model(ir, a, b);
        case (ir[15:12])
            4'b0001: rtag = ir[5] ? "R2 add immediate" : "R1 add register";
            4'b0101: rtag = ir[5] ? "R2 and immediate" : "R3 and register";
            default: rtag = "R4 complement";
        endcase
        if (is_op) begin
            exp_cc = classify(res);
            ftag = wv ? "R9 collision flags" : "R7 result flags";
        end else if (wv) begin
            exp_cc = classify(wd);
            ftag = "R8 write-back flags";
        end else begin
            ftag = "R10 flags hold";
        end
        @(negedge clk);
        if (is_op) begin
            chk(rf_we == 1'b1, rtag, {15'h0, rf_we}, 16'h1);
            chk(rf_dst == ir[11:9], rtag, {13'h0, rf_dst}, {13'h0, ir[11:9]});
            chk(rf_data == res, rtag, rf_data, res);
        end else begin
            chk(rf_we == 1'b0, wv ? "R8 no write strobe" : "R10 no write strobe",
                {15'h0, rf_we}, 16'h0);
        end
        chk({flag_n, flag_z, flag_p} == exp_cc, ftag, {13'h0, flag_n, flag_z, flag_p},
            {13'h0, exp_cc});
        chk($countones({flag_n, flag_z, flag_p}) == 1, "R6 one flag set",
            {13'h0, flag_n, flag_z, flag_p}, 16'h0);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: act=%h exp=%h", 16'h1, 16'h0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] a, b, ir, wd;
        logic [3:0]  opc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(rf_we == 1'b0 && {flag_n, flag_z, flag_p} == 3'b010, "R6 reset state",
            {12'h0, rf_we, flag_n, flag_z, flag_p}, 16'h2);
        rst_n = 1'b1;
        @(negedge clk);
        chk({flag_n, flag_z, flag_p} == 3'b010, "R6 after reset",
            {13'h0, flag_n, flag_z, flag_p}, 16'h2);

        // directed corners
        step(1, mk(4'b0001, 3'd2, 3'd1, 1'b1, 5'b00101), 16'd10, 16'hBEEF, 0, 0);
        step(1, mk(4'b0001, 3'd3, 3'd1, 1'b1, 5'b11110), 16'd1, 16'h1234, 0, 0);
        step(1, mk(4'b0001, 3'd4, 3'd4, 1'b0, 5'b00100), 16'h7FFF, 16'h0001, 0, 0);
        step(1, mk(4'b0101, 3'd5, 3'd0, 1'b0, 5'b00001), 16'hF0F0, 16'h0F0F, 0, 0);
        step(1, mk(4'b0101, 3'd5, 3'd0, 1'b1, 5'b10000), 16'hFFFF, 16'h0000, 0, 0);
        step(1, mk(4'b1001, 3'd6, 3'd6, 1'b1, 5'b11111), 16'hFFFF, 16'h5555, 0, 0);
        step(0, mk(4'b0001, 3'd1, 3'd1, 1'b0, 5'b00001), 16'h0005, 16'h0005, 0, 0);
        step(1, mk(4'b0000, 3'd1, 3'd1, 1'b0, 5'b00001), 16'h0005, 16'h0005, 0, 0);
        step(0, 16'h0, 16'h0, 16'h0, 1, 16'h8001);
        step(0, 16'h0, 16'h0, 16'h0, 1, 16'h0000);
        step(0, 16'h0, 16'h0, 16'h0, 1, 16'h0042);
        step(1, mk(4'b0001, 3'd7, 3'd2, 1'b1, 5'b00011), 16'd4, 16'h0, 1, 16'hFFFF);
        step(1, mk(4'b1001, 3'd0, 3'd2, 1'b0, 5'b00000), 16'hFFFF, 16'h0, 1, 16'h0007);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            case ($urandom % 5)
                0: opc = 4'b0001;
                1: opc = 4'b0101;
                2: opc = 4'b1001;
                3: opc = 4'($urandom);
                default: opc = 4'b0001;
            endcase
            ir = {opc, 12'($urandom)};
            case ($urandom % 6)
                0: a = 16'h0000;
                1: a = 16'hFFFF;
                2: a = 16'h7FFF;
                3: a = 16'h8000;
                default: a = 16'($urandom);
            endcase
            b  = ($urandom % 4 == 0) ? ~a : 16'($urandom);
            wd = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
            step(($urandom % 5) != 4, ir, a, b, ($urandom % 3) == 0, wd);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule